// File: doc/BRIEF.md
# Eight-Input Vectored Priority Interrupt Controller

This block collects up to eight interrupt requests and raises one interrupt line toward a processor. It presents a vector for the highest-ranked request that is not blocked. Software programs it through a byte-wide port with two addresses, selected by `addr0`.

After an initialization sequence, software uses command bytes to:
- change the mask,
- retire in-service levels,
- rotate the priority order,
- choose what an even-address read returns.

A one-cycle acknowledge strobe, or a polling read, moves the winning request into service and returns its vector. A separate per-input trigger register picks level or edge sensing for each input. An init-time flag forces level sensing on all eight inputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, in-service and request sets are empty. Input 0 ranks highest and input 7 lowest. `int_out` is low. An even-address read returns the request set and an odd-address read returns the mask.
- R2: An even-address write with bit 4 set starts initialization. In that word, bit 0 announces a mode word, bit 1 selects single mode (no cascade word), and bit 3 forces level sensing on all inputs. The following odd-address writes are taken in this order:
  - the vector base, whose bits 7:3 become `vec_out[7:3]`;
  - the cascade word, only when not in single mode;
  - the mode word, only when announced.
- R3: Once initialization is done, an odd-address write loads the mask, where a 1 disables that input. A masked request never raises `int_out`.
- R4: An edge-sensed input latches a request on a rising pin and keeps it until the request is acknowledged. A level-sensed input's request follows the pin level.
- R5: `int_out` is high exactly when some unmasked request ranks strictly above every in-service level that blocks it.
- R6: While `ack` is high, `vec_out` carries the base with the winning input number in bits 2:0. At the clock edge the winner's in-service bit is set and its edge request is cleared. With no winner, `vec_out` shows level 7 and nothing changes.
- R7: When mode-word bit 1 (automatic end of interrupt) is set, acknowledging does not set an in-service bit.
- R8: An even-address write with bits 4 and 3 clear is an end-of-interrupt/priority command, decoded from bits 7:5. Code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit of the level in bits 2:0.
- R9: Rotation commands:
  - code 101 clears the highest-ranked in-service bit and makes that level the lowest;
  - code 111 does the same for the level in bits 2:0;
  - code 110 only makes that level the lowest;
  - code 100 turns on rotation at automatic end of interrupt, and code 000 turns it off.
- R10: An even-address write with bit 4 clear and bit 3 set is a read/mode command. When its bit 1 is set, bit 0 selects the in-service set (1) or the request set (0) for later even-address reads.
- R11: In that command, bit 6 set loads special mask mode from bit 5. While that mode is on, masked in-service bits do not block lower-ranked requests.
- R12: In that command, bit 2 arms a poll. The next even-address read returns bit 7 set and the winning level in bits 2:0, or zero when nothing is pending. That read acknowledges the level as in R6.
- R13: The trigger register is written through `trig_we` and read on `trig_q`. A 1 selects level sensing for that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register port write strobe |
| rd_en | input | 1 | Register port read strobe |
| addr0 | input | 1 | Address select: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_in | input | 8 | Interrupt request pins |
| int_out | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge strobe, one cycle |
| vec_out | output | 8 | Vector for the current winner |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 8 | Trigger register write data |
| trig_q | output | 8 | Trigger register contents |

## Verification
The bench builds the controller in its fixed eight-input, three-bit-level configuration. That makes every rotation point of the rank order reachable, including a wrap from input 7 back to input 0 after the lowest level moves. Both initialization paths are driven: the cascaded path with a cascade word, and the single path with automatic end of interrupt. This shows that a skipped or extra odd-address word would land in the mask. A behavioural model is compared every cycle on `int_out`, `vec_out`, `trig_q` and any read data. It covers:
- special mask mode;
- polling, both with and without a pending request;
- switching between level and edge sensing.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NIN = 8;
    localparam int LW  = $clog2(NIN);
    localparam int DW  = 8;

    typedef logic [NIN-1:0] vec_t;
    typedef logic [LW-1:0]  lvl_t;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef enum logic [2:0] {
        EC_ROT_AEOI_OFF = 3'b000,
        EC_NS_EOI       = 3'b001,
        EC_NOP          = 3'b010,
        EC_SP_EOI       = 3'b011,
        EC_ROT_AEOI_ON  = 3'b100,
        EC_ROT_NS_EOI   = 3'b101,
        EC_SET_PRIO     = 3'b110,
        EC_ROT_SP_EOI   = 3'b111
    } eoi_cmd_e;

    typedef struct packed {
        logic     valid;
        eoi_cmd_e cmd;
        lvl_t     lvl;
    } eoi_req_t;

    typedef struct packed {
        logic [DW-1:LW] base;
        logic           level_all;
        logic           aeoi;
        logic           rd_isr;
        logic           smm;
        logic           rot_aeoi;
    } cfg_t;

    // Input number holding a given rank (rank 0 = highest) after lowest level lowp
    function automatic lvl_t rank_to_in(lvl_t lowp, lvl_t rank);
        return lowp + lvl_t'(1) + rank;
    endfunction
endpackage

// File: rtl/irq_cfg_dec.sv
module irq_cfg_dec
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr0,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output vec_t          mask,
    output eoi_req_t      eoi,
    output logic          init_clr,
    output logic          poll_armed
);
    init_st_e state;
    cfg_t     cfg_q;
    vec_t     mask_q;
    logic     need_mode, single_q, poll_q;

    wire is_init = wr_en && !addr0 && wdata[4];
    wire is_ocw  = wr_en && !addr0 && !wdata[4] && (state == ST_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READY;
            cfg_q     <= '0;
            mask_q    <= '0;
            need_mode <= 1'b0;
            single_q  <= 1'b0;
            poll_q    <= 1'b0;
        end else begin
            if (rd_en && !addr0)
                poll_q <= 1'b0;
            if (is_init) begin
                state          <= ST_BASE;
                need_mode      <= wdata[0];
                single_q       <= wdata[1];
                cfg_q.level_all <= wdata[3];
                cfg_q.aeoi     <= 1'b0;
                cfg_q.rd_isr   <= 1'b0;
                cfg_q.smm      <= 1'b0;
                cfg_q.rot_aeoi <= 1'b0;
                mask_q         <= '0;
                poll_q         <= 1'b0;
            end else if (wr_en && addr0) begin
                unique case (state)
                    ST_BASE: begin
                        cfg_q.base <= wdata[DW-1:LW];
                        if (!single_q)      state <= ST_CASC;
                        else if (need_mode) state <= ST_MODE;
                        else                state <= ST_READY;
                    end
                    ST_CASC: state <= need_mode ? ST_MODE : ST_READY;
                    ST_MODE: begin
                        cfg_q.aeoi <= wdata[1];
                        state      <= ST_READY;
                    end
                    default: mask_q <= wdata;
                endcase
            end else if (is_ocw) begin
                if (wdata[3]) begin
                    if (wdata[1]) cfg_q.rd_isr <= wdata[0];
                    if (wdata[2]) poll_q       <= 1'b1;
                    if (wdata[6]) cfg_q.smm    <= wdata[5];
                end else if (wdata[7:5] == EC_ROT_AEOI_ON) begin
                    cfg_q.rot_aeoi <= 1'b1;
                end else if (wdata[7:5] == EC_ROT_AEOI_OFF) begin
                    cfg_q.rot_aeoi <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        eoi.valid = is_ocw && !wdata[3];
        eoi.cmd   = eoi_cmd_e'(wdata[7:5]);
        eoi.lvl   = wdata[LW-1:0];
    end

    assign cfg        = cfg_q;
    assign mask       = mask_q;
    assign init_clr   = is_init;
    assign poll_armed = poll_q;

    p_init_start_r2: assert property (@(posedge clk) disable iff (rst)
        is_init |=> (state == ST_BASE));
    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr0 && state == ST_READY) |=> (mask == $past(wdata)));
    p_smm_load_r11: assert property (@(posedge clk) disable iff (rst)
        (is_ocw && wdata[3] && wdata[6]) |=> (cfg.smm == $past(wdata[5])));
endmodule

// File: rtl/irq_prio_res.sv
module irq_prio_res
    import irq_pkg::*;
(
    input  vec_t req,
    input  vec_t mask,
    input  vec_t isr,
    input  lvl_t lowp,
    input  logic smm,
    output logic pend,
    output lvl_t win,
    output logic top_hit,
    output lvl_t top_lvl
);
    lvl_t idx [NIN];
    vec_t elig, blk;
    logic req_hit, blk_hit;
    lvl_t req_rank, blk_rank;

    for (genvar k = 0; k < NIN; k++) begin : g_rank
        assign idx[k] = rank_to_in(lowp, lvl_t'(k));
    end

    assign elig = req & ~mask;
    assign blk  = smm ? (isr & ~mask) : isr;

    always_comb begin
        req_hit  = 1'b0; req_rank = '0; win     = '0;
        blk_hit  = 1'b0; blk_rank = '0;
        top_hit  = 1'b0; top_lvl  = '0;
        for (int k = NIN - 1; k >= 0; k--) begin
            if (elig[idx[k]]) begin
                req_hit  = 1'b1;
                req_rank = lvl_t'(k);
                win      = idx[k];
            end
            if (blk[idx[k]]) begin
                blk_hit  = 1'b1;
                blk_rank = lvl_t'(k);
            end
            if (isr[idx[k]]) begin
                top_hit = 1'b1;
                top_lvl = idx[k];
            end
        end
        pend = req_hit && (!blk_hit || (req_rank < blk_rank));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr0,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] irq_in,
    output logic       int_out,
    input  logic       ack,
    output logic [7:0] vec_out,
    input  logic       trig_we,
    input  logic [7:0] trig_wdata,
    output logic [7:0] trig_q
);
    cfg_t     cfg;
    vec_t     mask, req_q, isr_q, pin_q, trig_r, req_n, isr_n, lvl_mode;
    eoi_req_t eoi;
    logic     init_clr, poll_armed, pend, top_hit, take;
    lvl_t     win, top_lvl, lowp_q, lowp_n;

    irq_cfg_dec u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr0(addr0),
        .wdata(wdata), .cfg(cfg), .mask(mask), .eoi(eoi),
        .init_clr(init_clr), .poll_armed(poll_armed)
    );

    irq_prio_res u_res (
        .req(req_q), .mask(mask), .isr(isr_q), .lowp(lowp_q), .smm(cfg.smm),
        .pend(pend), .win(win), .top_hit(top_hit), .top_lvl(top_lvl)
    );

    assign lvl_mode = {NIN{cfg.level_all}} | trig_r;
    assign take     = ack || (rd_en && !addr0 && poll_armed);

    always_comb begin
        req_n  = req_q;
        isr_n  = isr_q;
        lowp_n = lowp_q;
        if (take && pend) begin
            if (!cfg.aeoi)         isr_n[win] = 1'b1;
            else if (cfg.rot_aeoi) lowp_n     = win;
            if (!lvl_mode[win])    req_n[win] = 1'b0;
        end
        if (eoi.valid) begin
            unique case (eoi.cmd)
                EC_NS_EOI:     if (top_hit) isr_n[top_lvl] = 1'b0;
                EC_ROT_NS_EOI: if (top_hit) begin
                                   isr_n[top_lvl] = 1'b0;
                                   lowp_n         = top_lvl;
                               end
                EC_SP_EOI:     isr_n[eoi.lvl] = 1'b0;
                EC_ROT_SP_EOI: begin
                                   isr_n[eoi.lvl] = 1'b0;
                                   lowp_n         = eoi.lvl;
                               end
                EC_SET_PRIO:   lowp_n = eoi.lvl;
                default: ;
            endcase
        end
        for (int i = 0; i < NIN; i++) begin
            if (lvl_mode[i])                  req_n[i] = irq_in[i];
            else if (irq_in[i] && !pin_q[i])  req_n[i] = 1'b1;
        end
        if (init_clr) begin
            req_n  = '0;
            isr_n  = '0;
            lowp_n = lvl_t'(NIN - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            isr_q  <= '0;
            pin_q  <= '0;
            trig_r <= '0;
            lowp_q <= lvl_t'(NIN - 1);
        end else begin
            req_q  <= req_n;
            isr_q  <= isr_n;
            pin_q  <= irq_in;
            lowp_q <= lowp_n;
            if (trig_we) trig_r <= trig_wdata;
        end
    end

    always_comb begin
        if (addr0)           rdata = mask;
        else if (poll_armed) rdata = {pend, {(DW-LW-1){1'b0}}, pend ? win : lvl_t'(0)};
        else if (cfg.rd_isr) rdata = isr_q;
        else                 rdata = req_q;
    end

    assign int_out = pend;
    assign vec_out = {cfg.base, pend ? win : lvl_t'(NIN - 1)};
    assign trig_q  = trig_r;

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!int_out && vec_out[LW-1:0] == lvl_t'(NIN - 1)));
    p_int_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (|(req_q & ~mask)));
    p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && pend && !cfg.aeoi && !eoi.valid && !init_clr) |=> isr_q[$past(win)]);
    p_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !pend && !eoi.valid && !init_clr) |=> (isr_q == $past(isr_q)));
    p_aeoi_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && cfg.aeoi && !eoi.valid && !init_clr) |=> (isr_q == $past(isr_q)));
    p_ns_eoi_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi.valid && eoi.cmd == EC_NS_EOI && top_hit && !take) |=> !isr_q[$past(top_lvl)]);
    p_poll_once_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr0 && !wr_en) |=> !poll_armed);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, rd_en = 0, addr0 = 0, ack = 0, trig_we = 0;
    logic [7:0] wdata = 0, irq_in = 0, trig_wdata = 0;
    logic [7:0] rdata, vec_out, trig_q;
    logic int_out;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr0(addr0),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
        .ack(ack), .vec_out(vec_out), .trig_we(trig_we),
        .trig_wdata(trig_wdata), .trig_q(trig_q)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_req, m_isr, m_mask, m_pin, m_trig, m_base;
    int m_lowp, m_st;
    bit m_lvl_all, m_single, m_need4, m_aeoi, m_rdisr, m_smm, m_rot, m_poll;

    function automatic void m_pick(output bit hit, output int lvl);
        int br = 8, rr = 8;
        lvl = 7;
        for (int k = 0; k < 8; k++) begin
            int i = (m_lowp + 1 + k) % 8;
            if (m_isr[i] && !(m_smm && m_mask[i]) && br == 8) br = k;
            if (m_req[i] && !m_mask[i] && rr == 8) begin rr = k; lvl = i; end
        end
        hit = rr < br;
        if (!hit) lvl = 7;
    endfunction

    function automatic int m_top();
        for (int k = 0; k < 8; k++)
            if (m_isr[(m_lowp + 1 + k) % 8]) return (m_lowp + 1 + k) % 8;
        return -1;
    endfunction

    always @(posedge clk) begin
        bit [7:0] nreq, nisr, lm;
        int nlow, w, t;
        bit hit;
        if (rst) begin
            m_req = 0; m_isr = 0; m_mask = 0; m_pin = 0; m_trig = 0; m_base = 0;
            m_lowp = 7; m_st = 0; m_lvl_all = 0; m_single = 0; m_need4 = 0;
            m_aeoi = 0; m_rdisr = 0; m_smm = 0; m_rot = 0; m_poll = 0;
        end else begin
            m_pick(hit, w);
            nreq = m_req; nisr = m_isr; nlow = m_lowp;
            lm = {8{m_lvl_all}} | m_trig;
            if ((ack || (rd_en && !addr0 && m_poll)) && hit) begin
                if (!m_aeoi) nisr[w] = 1; else if (m_rot) nlow = w;
                if (!lm[w]) nreq[w] = 0;
            end
            if (rd_en && !addr0) m_poll = 0;
            if (wr_en && !addr0 && !wdata[4] && m_st == 0) begin
                t = m_top();
                if (wdata[3]) begin
                    if (wdata[1]) m_rdisr = wdata[0];
                    if (wdata[2]) m_poll = 1;
                    if (wdata[6]) m_smm = wdata[5];
                end else case (wdata[7:5])
                    3'd0: m_rot = 0;
                    3'd4: m_rot = 1;
                    3'd1: if (t >= 0) nisr[t] = 0;
                    3'd5: if (t >= 0) begin nisr[t] = 0; nlow = t; end
                    3'd3: nisr[wdata[2:0]] = 0;
                    3'd7: begin nisr[wdata[2:0]] = 0; nlow = wdata[2:0]; end
                    3'd6: nlow = wdata[2:0];
                    default: ;
                endcase
            end
            for (int i = 0; i < 8; i++) begin
                if (lm[i]) nreq[i] = irq_in[i];
                else if (irq_in[i] && !m_pin[i]) nreq[i] = 1;
            end
            if (wr_en && addr0) begin
                case (m_st)
                    1: begin m_base = wdata & 8'hF8; m_st = !m_single ? 2 : (m_need4 ? 3 : 0); end
                    2: m_st = m_need4 ? 3 : 0;
                    3: begin m_aeoi = wdata[1]; m_st = 0; end
                    default: m_mask = wdata;
                endcase
            end
            if (wr_en && !addr0 && wdata[4]) begin
                m_st = 1; m_need4 = wdata[0]; m_single = wdata[1]; m_lvl_all = wdata[3];
                m_aeoi = 0; m_rdisr = 0; m_smm = 0; m_rot = 0; m_mask = 0; m_poll = 0;
                nreq = 0; nisr = 0; nlow = 7;
            end
            if (trig_we) m_trig = trig_wdata;
            m_pin = irq_in; m_req = nreq; m_isr = nisr; m_lowp = nlow;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit hit; int w;
        m_pick(hit, w);
        chk("R5 int_out", {7'd0, int_out}, {7'd0, hit});
        chk("R6 vec_out", vec_out, {m_base[7:3], 3'(w)});
        chk("R13 trig_q", trig_q, m_trig);
        if (rd_en)
            chk("R10 rdata", rdata, addr0 ? m_mask :
                m_poll ? {hit, 4'd0, hit ? 3'(w) : 3'd0} : (m_rdisr ? m_isr : m_req));
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(bit a, bit [7:0] d);
        wr_en = 1; addr0 = a; wdata = d; tick(); wr_en = 0; addr0 = 0;
    endtask

    task automatic rd(bit a, bit [7:0] exp, string tag);
        rd_en = 1; addr0 = a; #1 chk(tag, rdata, exp); tick(); rd_en = 0; addr0 = 0;
    endtask

    task automatic do_ack(bit [7:0] exp, string tag);
        ack = 1; #1 chk(tag, vec_out, exp); tick(); ack = 0;
    endtask

    task automatic pins(bit [7:0] v);
        irq_in = v; tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 int_out", {7'd0, int_out}, 8'd0);
        rd(0, 8'h00, "R1 irr");
        rd(1, 8'h00, "R1 mask");
        // R2 cascaded init with cascade and mode words
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);
        rd(1, 8'h00, "R2 mask untouched by init words");
        wr(1, 8'h20); rd(1, 8'h20, "R3 mask load"); wr(1, 8'h00);
        // R4/R5/R6 edge requests and acknowledge
        pins(8'h08); pins(8'h28);
        chk("R5 raised", {7'd0, int_out}, 8'd1);
        chk("R2 vector base", vec_out, 8'h43);
        do_ack(8'h43, "R6 ack vec");
        chk("R5 blocked by in-service", {7'd0, int_out}, 8'd0);
        wr(0, 8'h0B); rd(0, 8'h08, "R10 isr read");
        wr(0, 8'h0A); rd(0, 8'h20, "R4 edge req cleared on ack");
        pins(8'h2A);
        chk("R5 higher rank preempts", {7'd0, int_out}, 8'd1);
        do_ack(8'h41, "R6 ack vec 1");
        wr(0, 8'h20); wr(0, 8'h0B); rd(0, 8'h08, "R8 nonspecific eoi");
        wr(0, 8'h63); rd(0, 8'h00, "R8 specific eoi");
        chk("R5 pending after eoi", {7'd0, int_out}, 8'd1);
        wr(1, 8'h20); chk("R3 masked", {7'd0, int_out}, 8'd0);
        wr(1, 8'hFF); do_ack(8'h47, "R6 spurious");
        rd(0, 8'h00, "R6 spurious leaves isr");
        wr(1, 8'h00); pins(8'h00);
        // R9 rotation
        wr(0, 8'hC4); pins(8'h44);
        do_ack(8'h45, "R9 set priority");
        chk("R9 blocked", {7'd0, int_out}, 8'd0);
        wr(0, 8'hE5); do_ack(8'h46, "R9 rotate specific");
        wr(0, 8'hA0); do_ack(8'h42, "R9 rotate nonspecific");
        wr(0, 8'h20); chk("R8 all retired", {7'd0, int_out}, 8'd0);
        // R11 special mask mode
        wr(0, 8'hC7); pins(8'h00); pins(8'h02);
        do_ack(8'h41, "R11 ack 1");
        wr(1, 8'h02); pins(8'h12);
        chk("R11 blocked without smm", {7'd0, int_out}, 8'd0);
        wr(0, 8'h68);
        chk("R11 passes with smm", {7'd0, int_out}, 8'd1);
        do_ack(8'h44, "R11 ack 4");
        wr(0, 8'h48); wr(0, 8'h20); wr(0, 8'h20); wr(1, 8'h00);
        rd(0, 8'h00, "R8 isr empty");
        // R12 poll
        pins(8'h52);
        wr(0, 8'h0C); rd(0, 8'h86, "R12 poll result");
        rd(0, 8'h40, "R12 poll acknowledged");
        wr(0, 8'h20);
        wr(0, 8'h0C); rd(0, 8'h00, "R12 poll empty");
        // R13 / R4 level sensing via trigger register
        wr(0, 8'h0A);
        trig_we = 1; trig_wdata = 8'h10; tick(); trig_we = 0;
        chk("R13 trig readback", trig_q, 8'h10);
        tick();
        rd(0, 8'h10, "R4 level follows pin high");
        pins(8'h42); tick();
        rd(0, 8'h00, "R4 level drops with pin");
        trig_we = 1; trig_wdata = 8'h00; tick(); trig_we = 0;
        // R2/R7 single-mode init with automatic eoi
        wr(0, 8'h13); wr(1, 8'h80); wr(1, 8'h03);
        rd(1, 8'h00, "R2 single mode skips cascade");
        pins(8'h00); pins(8'h01);
        do_ack(8'h80, "R7 ack vec");
        wr(0, 8'h0B); rd(0, 8'h00, "R7 isr stays clear");
        wr(0, 8'h80); pins(8'h05);
        do_ack(8'h82, "R9 aeoi ack 2");
        pins(8'h0F);
        chk("R9 rotate in aeoi", vec_out, 8'h83);
        do_ack(8'h83, "R9 aeoi ack 3");
        tick();
        summary();
    end
endmodule